// File: doc/BRIEF.md
# Plug-and-Play Configuration Register Bank

This block holds the configuration space of a peripheral controller that contains several logical devices. The host reaches it through two adjacent I/O addresses. The first is an index port and the second is a data port. A strap input, sampled during hardware reset, places the pair at 2Eh/2Fh or at 4Eh/4Fh. The host writes a register index to the index port and then reads or writes the data port. A device-select register picks which logical device sees the per-device indices. The host bus protocol is decoded upstream, so the block only sees single-cycle read and write strobes with an address and a data byte.

Each logical device has an activate bit, two 16-bit I/O base addresses, an IRQ number with a wake flag, an IRQ type, two DMA channel selects and one vendor byte. The bank drives one enable line per device. A device is enabled only when all of the following hold: it is activated, neither fast-disable mask that covers it is set, the global enable is on, and the external controller is not holding it off. There are two reset sources. A host software reset returns all device standard registers to their defaults. A hardware reset also clears the global registers and the vendor bytes, and it clears the lock bits unless the lock-retain input is high.

The default build has six devices: 0 floppy, 1 parallel, 2 serial A, 3 serial B, 4 keyboard and 5 general-purpose I/O. Device 5 is not a legacy device.

Top module: `pnp_cfg_bank`

## Requirements
- R1: The index port is at 002Eh and the data port at 002Fh when `strap_hi` was 0 during the last hardware-reset cycle. They are at 004Eh and 004Fh when it was 1. Reads of any other address return 00h, and writes to any other address change nothing.
- R2: Index 07h holds the device number, 8 bits, readable. Indices 30h and above reach the selected device. While the device number is 6 or more, those indices read 00h and ignore writes.
- R3: Per-device map. 30h bit0 is the activate bit. 60h is the high byte and 61h the low byte of base address 0. 62h is the high byte and 63h the low byte of base address 1. 70h bits[4:0] hold the IRQ number (bits[3:0]) and the wake flag (bit4). 71h bits[1:0] hold the IRQ type. 74h bits[2:0] hold DMA select 0 and 75h bits[2:0] hold DMA select 1. F0h is a full vendor byte. Unimplemented bits and indices read 0. All of these registers are accessible whether or not the device is active.
- R4: Global registers. 21h bit0 is the global enable. 22h is fast-disable A, where bit i set disables device i; only bits 0 to 3 are stored. 23h is fast-disable B with the same bit meaning; only bits 0 to 4 are stored. Bits that are not stored read 0.
- R5: `dev_en[i]` = activate[i] AND NOT fastA[i] AND NOT fastB[i] AND global enable AND NOT `ext_override[i]`. It follows a register write on the next cycle.
- R6: `ext_override[i]` forces `dev_en[i]` low in the same cycle, without a clock edge.
- R7: A cycle with `sw_rst` high does the following. It clears every activate bit. It reloads base 0 with 03F0h, 0378h, 03F8h, 02F8h, 0060h and 0000h for devices 0 to 5. It reloads base 1 with 03F7h for device 0, 0064h for device 4 and 0000h for the others. It sets IRQ to 0, IRQ type to 3 and both DMA selects to 4. It leaves the vendor bytes, the global registers, the index, the device number and the locks unchanged. Any write in that cycle is ignored.
- R8: A cycle with `hw_rst_n` low does every R7 action. It also clears the vendor bytes, the index, the device number and both fast-disable registers, sets the global enable to 1, and latches `strap_hi`. It clears both lock bits only when `lock_retain` is 0.
- R9: Lock register 28h, bits[1:0]. Writing a 1 sets a bit, writing a 0 has no effect, and only R8 clears them. While bit0 is set, writes to 21h to 23h are ignored. While bit1 is set, writes to 60h to 63h, 70h, 71h, 74h and 75h are ignored. The activate bit and F0h stay writable.
- R10: `io_rdata` is 00h whenever `io_rd` is low. The index port reads back the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Synchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous host software reset, active high |
| strap_hi | input | 1 | Port-pair select strap, latched in hardware reset |
| lock_retain | input | 1 | Keeps lock bits through hardware reset when high |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| ext_override | input | NDEV | External controller hold-off, one bit per device |
| dev_en | output | NDEV | Device enables |

## Verification
The bench targets the cases a design is most likely to get wrong. A wrong mask would store bits outside the fast-disable masks and disable the GPIO device. If the hardware-reset and software-reset paths were merged, the vendor byte would vanish on a software reset, or locks would clear while lock-retain is high. If the lock were applied only to data, locked resource registers would still change while activate and F0h stayed writable. An out-of-range device number left to alias a real device would let 30h writes silently activate it. The bench also moves the port pair with the strap, and it checks that the old pair stops responding.

// File: rtl/pnp_cfg_bank.sv
module pnp_cfg_bank #(
  parameter int NDEV = 6,
  parameter logic [NDEV-1:0] FDA_MASK = 6'b001111,
  parameter logic [NDEV-1:0] FDB_MASK = 6'b011111,
  parameter logic [NDEV*16-1:0] DEF_BASE0 =
    {16'h0000, 16'h0060, 16'h02F8, 16'h03F8, 16'h0378, 16'h03F0},
  parameter logic [NDEV*16-1:0] DEF_BASE1 =
    {16'h0000, 16'h0064, 16'h0000, 16'h0000, 16'h0000, 16'h03F7}
) (
  input  logic            clk,
  input  logic            hw_rst_n,
  input  logic            sw_rst,
  input  logic            strap_hi,
  input  logic            lock_retain,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [15:0]     io_addr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic [NDEV-1:0] ext_override,
  output logic [NDEV-1:0] dev_en
);
  localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic            base_hi;
  logic [7:0]      idx, ldn;
  logic            gen;
  logic [NDEV-1:0] fda, fdb;
  logic [1:0]      lock;
  logic [NDEV-1:0] act;
  logic [15:0]     b0   [NDEV];
  logic [15:0]     b1   [NDEV];
  logic [4:0]      irq  [NDEV];
  logic [1:0]      ityp [NDEV];
  logic [2:0]      dma0 [NDEV];
  logic [2:0]      dma1 [NDEV];
  logic [7:0]      ven  [NDEV];
  logic [7:0]      rd_reg;

  wire [15:0]     port_base = base_hi ? 16'h004E : 16'h002E;
  wire            hit_idx   = (io_addr == port_base);
  wire            hit_dat   = (io_addr == port_base + 16'd1);
  wire            ldn_ok    = (ldn < 8'(NDEV));
  wire [SELW-1:0] dsel      = ldn[SELW-1:0];
  wire            wr_ok     = io_wr & ~sw_rst;
  wire            dev_wr    = wr_ok & hit_dat & ldn_ok & (idx >= 8'h30);
  wire            res_open  = ~lock[1];

  always_ff @(posedge clk) begin
    if (!hw_rst_n) begin
      base_hi <= strap_hi;
      idx     <= '0;
      ldn     <= '0;
      gen     <= 1'b1;
      fda     <= '0;
      fdb     <= '0;
      if (!lock_retain) lock <= '0;
    end else if (wr_ok) begin
      if (hit_idx) idx <= io_wdata;
      else if (hit_dat) begin
        case (idx)
          8'h07: ldn <= io_wdata;
          8'h21: if (!lock[0]) gen <= io_wdata[0];
          8'h22: if (!lock[0]) fda <= io_wdata[NDEV-1:0] & FDA_MASK;
          8'h23: if (!lock[0]) fdb <= io_wdata[NDEV-1:0] & FDB_MASK;
          8'h28: lock <= lock | io_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NDEV; i++) begin
      if (!hw_rst_n || sw_rst) begin
        act[i]  <= 1'b0;
        b0[i]   <= DEF_BASE0[i*16 +: 16];
        b1[i]   <= DEF_BASE1[i*16 +: 16];
        irq[i]  <= '0;
        ityp[i] <= 2'b11;
        dma0[i] <= 3'b100;
        dma1[i] <= 3'b100;
        if (!hw_rst_n) ven[i] <= '0;
      end else if (dev_wr && dsel == SELW'(i)) begin
        case (idx)
          8'h30: act[i] <= io_wdata[0];
          8'h60: if (res_open) b0[i][15:8] <= io_wdata;
          8'h61: if (res_open) b0[i][7:0]  <= io_wdata;
          8'h62: if (res_open) b1[i][15:8] <= io_wdata;
          8'h63: if (res_open) b1[i][7:0]  <= io_wdata;
          8'h70: if (res_open) irq[i]  <= io_wdata[4:0];
          8'h71: if (res_open) ityp[i] <= io_wdata[1:0];
          8'h74: if (res_open) dma0[i] <= io_wdata[2:0];
          8'h75: if (res_open) dma1[i] <= io_wdata[2:0];
          8'hF0: ven[i] <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_reg = '0;
    case (idx)
      8'h07: rd_reg = ldn;
      8'h21: rd_reg = {7'b0, gen};
      8'h22: rd_reg = 8'(fda);
      8'h23: rd_reg = 8'(fdb);
      8'h28: rd_reg = {6'b0, lock};
      default:
        if (ldn_ok) begin
          case (idx)
            8'h30: rd_reg = {7'b0, act[dsel]};
            8'h60: rd_reg = b0[dsel][15:8];
            8'h61: rd_reg = b0[dsel][7:0];
            8'h62: rd_reg = b1[dsel][15:8];
            8'h63: rd_reg = b1[dsel][7:0];
            8'h70: rd_reg = {3'b0, irq[dsel]};
            8'h71: rd_reg = {6'b0, ityp[dsel]};
            8'h74: rd_reg = {5'b0, dma0[dsel]};
            8'h75: rd_reg = {5'b0, dma1[dsel]};
            8'hF0: rd_reg = ven[dsel];
            default: rd_reg = '0;
          endcase
        end
    endcase
  end

  assign io_rdata = !io_rd  ? 8'h00 :
                    hit_idx ? idx    :
                    hit_dat ? rd_reg : 8'h00;

  assign dev_en = act & ~fda & ~fdb & {NDEV{gen}} & ~ext_override;

endmodule

module pnp_cfg_bank_chk #(
  parameter int NDEV = 6
) (
  input logic            clk,
  input logic            hw_rst_n,
  input logic            sw_rst,
  input logic            io_rd,
  input logic [7:0]      io_rdata,
  input logic [NDEV-1:0] ext_override,
  input logic [NDEV-1:0] dev_en,
  input logic [1:0]      lock,
  input logic            gen
);
  AST_OVR_FORCES_OFF: assert property (@(posedge clk) disable iff (!hw_rst_n) (ext_override & dev_en) == '0); // R6
  AST_GEN_GATES_ALL: assert property (@(posedge clk) disable iff (!hw_rst_n) !gen |-> dev_en == '0); // R5
  AST_SWRST_DEACT: assert property (@(posedge clk) disable iff (!hw_rst_n) sw_rst |=> dev_en == '0); // R7
  AST_HWRST_DEACT: assert property (@(posedge clk) !hw_rst_n |=> dev_en == '0); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!hw_rst_n) hw_rst_n |=> (lock & $past(lock)) == $past(lock)); // R9
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!hw_rst_n) !io_rd |-> io_rdata == 8'h00); // R10
endmodule

bind pnp_cfg_bank pnp_cfg_bank_chk #(.NDEV(NDEV)) chk_i (
  .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .io_rd(io_rd),
  .io_rdata(io_rdata), .ext_override(ext_override), .dev_en(dev_en),
  .lock(lock), .gen(gen)
);

// File: tb/pnp_cfg_bank_tb.sv
`timescale 1ns/1ps
module pnp_cfg_bank_tb_top;
  localparam int N = 6;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic hw_rst_n = 1'b0, sw_rst = 1'b0, strap_hi = 1'b0, lock_retain = 1'b0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic [N-1:0] ext_override = '0, dev_en;

  logic n_hw = 1'b0, n_sw = 1'b0, n_strap = 1'b0, n_ret = 1'b0;
  logic [N-1:0] n_ovr = '0;

  pnp_cfg_bank dut_i (.*);

  int checks = 0, failures = 0;
  bit armed = 0;
  string cur_req = "R1";

  logic [15:0] m_base;
  logic [7:0]  m_idx, m_ldn, m_fa, m_fb, m_lock;
  logic        m_gen;
  logic        m_act [N];
  logic [15:0] m_b0 [N], m_b1 [N];
  logic [7:0]  m_irq [N], m_typ [N], m_d0 [N], m_d1 [N], m_ven [N];
  logic [15:0] def0 [N] = '{16'h03F0, 16'h0378, 16'h03F8, 16'h02F8, 16'h0060, 16'h0000};
  logic [15:0] def1 [N] = '{16'h03F7, 16'h0000, 16'h0000, 16'h0000, 16'h0064, 16'h0000};

  task automatic chk(string tag, logic [7:0] act_v, logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic logic [7:0] m_reg();
    int d = m_ldn;
    case (m_idx)
      8'h07: return m_ldn;
      8'h21: return {7'b0, m_gen};
      8'h22: return m_fa;
      8'h23: return m_fb;
      8'h28: return m_lock;
      default: ;
    endcase
    if (m_idx < 8'h30 || d >= N) return 8'h00;
    case (m_idx)
      8'h30: return {7'b0, m_act[d]};
      8'h60: return m_b0[d][15:8];
      8'h61: return m_b0[d][7:0];
      8'h62: return m_b1[d][15:8];
      8'h63: return m_b1[d][7:0];
      8'h70: return m_irq[d];
      8'h71: return m_typ[d];
      8'h74: return m_d0[d];
      8'h75: return m_d1[d];
      8'hF0: return m_ven[d];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_rdata();
    if (!io_rd) return 8'h00;
    if (io_addr == m_base) return m_idx;
    if (io_addr == m_base + 16'd1) return m_reg();
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_en();
    logic [7:0] e = '0;
    for (int i = 0; i < N; i++)
      e[i] = m_act[i] && !m_fa[i] && !m_fb[i] && m_gen && !ext_override[i];
    return e;
  endfunction

  task automatic m_update();
    int d = m_ldn;
    if (!hw_rst_n || sw_rst) begin
      for (int i = 0; i < N; i++) begin
        m_act[i] = 0; m_b0[i] = def0[i]; m_b1[i] = def1[i];
        m_irq[i] = 0; m_typ[i] = 3; m_d0[i] = 4; m_d1[i] = 4;
        if (!hw_rst_n) m_ven[i] = 0;
      end
      if (!hw_rst_n) begin
        m_base = strap_hi ? 16'h004E : 16'h002E;
        m_idx = 0; m_ldn = 0; m_gen = 1; m_fa = 0; m_fb = 0;
        if (!lock_retain) m_lock = 0;
      end
      return;
    end
    if (!io_wr) return;
    if (io_addr == m_base) begin m_idx = io_wdata; return; end
    if (io_addr != m_base + 16'd1) return;
    case (m_idx)
      8'h07: m_ldn = io_wdata;
      8'h21: if (!m_lock[0]) m_gen = io_wdata[0];
      8'h22: if (!m_lock[0]) m_fa = io_wdata & 8'h0F;
      8'h23: if (!m_lock[0]) m_fb = io_wdata & 8'h1F;
      8'h28: m_lock = m_lock | (io_wdata & 8'h03);
      default: ;
    endcase
    if (m_idx < 8'h30 || d >= N) return;
    case (m_idx)
      8'h30: m_act[d] = io_wdata[0];
      8'h60: if (!m_lock[1]) m_b0[d][15:8] = io_wdata;
      8'h61: if (!m_lock[1]) m_b0[d][7:0] = io_wdata;
      8'h62: if (!m_lock[1]) m_b1[d][15:8] = io_wdata;
      8'h63: if (!m_lock[1]) m_b1[d][7:0] = io_wdata;
      8'h70: if (!m_lock[1]) m_irq[d] = io_wdata & 8'h1F;
      8'h71: if (!m_lock[1]) m_typ[d] = io_wdata & 8'h03;
      8'h74: if (!m_lock[1]) m_d0[d] = io_wdata & 8'h07;
      8'h75: if (!m_lock[1]) m_d1[d] = io_wdata & 8'h07;
      8'hF0: m_ven[d] = io_wdata;
      default: ;
    endcase
  endtask

  task automatic cyc(logic w, logic r, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
    hw_rst_n = n_hw; sw_rst = n_sw; strap_hi = n_strap; lock_retain = n_ret;
    ext_override = n_ovr;
    #1;
    if (armed) begin
      chk(r ? cur_req : "R10", io_rdata, m_rdata());
      chk(ext_override != 0 ? "R6" : "R5", 8'(dev_en), m_en());
    end
    @(posedge clk);
    m_update();
    if (!hw_rst_n) armed = 1;
  endtask

  task automatic idle(); cyc(0, 0, 16'h0, 8'h0); endtask
  task automatic cfg_wr(logic [7:0] i, logic [7:0] d);
    cyc(1, 0, m_base, i); cyc(1, 0, m_base + 16'd1, d);
  endtask
  task automatic cfg_rd(logic [7:0] i);
    cyc(1, 0, m_base, i); cyc(0, 1, m_base + 16'd1, 8'h0);
  endtask
  task automatic hw_reset(logic strap, logic ret);
    n_hw = 0; n_strap = strap; n_ret = ret;
    repeat (2) idle();
    n_hw = 1; idle();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-reqs actual=timeout expected=done");
    report();
  end

  initial begin
    hw_reset(0, 0);
    cur_req = "R1";
    cyc(0, 1, 16'h002E, 0);
    cyc(1, 0, 16'h004E, 8'h07); cyc(1, 0, 16'h004F, 8'h03);
    cyc(0, 1, 16'h004F, 0); cyc(0, 1, 16'h002E, 0);
    cur_req = "R3";
    for (int dv = 0; dv < N; dv++) begin
      cfg_wr(8'h07, 8'(dv));
      foreach (def0[k]) ;
      cfg_rd(8'h60); cfg_rd(8'h61); cfg_rd(8'h62); cfg_rd(8'h63);
      cfg_rd(8'h70); cfg_rd(8'h71); cfg_rd(8'h74); cfg_rd(8'h75);
      cfg_wr(8'hF0, 8'hA0 + 8'(dv)); cfg_rd(8'hF0);
      cfg_wr(8'h30, 8'hFF); cfg_rd(8'h30);
    end
    cfg_wr(8'h07, 8'h02);
    cfg_wr(8'h70, 8'hFF); cfg_rd(8'h70);
    cfg_wr(8'h71, 8'hFF); cfg_rd(8'h71);
    cfg_wr(8'h74, 8'hFF); cfg_rd(8'h74);
    cfg_wr(8'h75, 8'hFE); cfg_rd(8'h75);
    cfg_wr(8'h62, 8'h12); cfg_wr(8'h63, 8'h34); cfg_rd(8'h62); cfg_rd(8'h63);
    cfg_rd(8'h40); cfg_rd(8'h31); cfg_rd(8'h15);
    cur_req = "R4";
    cfg_wr(8'h22, 8'hFF); cfg_rd(8'h22); idle();
    cfg_wr(8'h22, 8'h00);
    cfg_wr(8'h23, 8'hFF); cfg_rd(8'h23); idle();
    cfg_wr(8'h23, 8'h00);
    cfg_wr(8'h21, 8'h00); cfg_rd(8'h21); idle();
    cfg_wr(8'h21, 8'h01);
    n_ovr = 6'b100101; idle(); idle();
    n_ovr = 6'b011010; idle();
    n_ovr = '0; idle();
    cur_req = "R2";
    cfg_wr(8'h07, 8'h07); cfg_rd(8'h07);
    cfg_wr(8'h30, 8'h00); cfg_rd(8'h30); cfg_rd(8'hF0);
    cfg_wr(8'h07, 8'h06); cfg_wr(8'h60, 8'h55); cfg_rd(8'h60);
    cfg_wr(8'h07, 8'h04); cfg_rd(8'h30); cfg_rd(8'h60);
    cur_req = "R9";
    cfg_wr(8'h28, 8'h01); cfg_rd(8'h28);
    cfg_wr(8'h21, 8'h00); cfg_rd(8'h21);
    cfg_wr(8'h22, 8'h0F); cfg_rd(8'h22);
    cfg_wr(8'h60, 8'h99); cfg_rd(8'h60);
    cfg_wr(8'h28, 8'h02); cfg_wr(8'h28, 8'h00); cfg_rd(8'h28);
    cfg_wr(8'h61, 8'h77); cfg_rd(8'h61);
    cfg_wr(8'h70, 8'h0A); cfg_rd(8'h70);
    cfg_wr(8'h30, 8'h00); cfg_rd(8'h30);
    cfg_wr(8'hF0, 8'h5C); cfg_rd(8'hF0);
    cfg_wr(8'h30, 8'h01);
    cur_req = "R7";
    cyc(1, 0, m_base, 8'h30);
    n_sw = 1; cyc(1, 0, m_base + 16'd1, 8'h00); cyc(1, 0, m_base, 8'h60);
    n_sw = 0; idle();
    cfg_rd(8'h30); cfg_rd(8'h60); cfg_rd(8'h61); cfg_rd(8'hF0);
    cfg_rd(8'h28); cfg_rd(8'h21); cfg_rd(8'h07); cfg_rd(8'h71); cfg_rd(8'h74);
    cfg_wr(8'h07, 8'h00); cfg_rd(8'h62); cfg_rd(8'h63);
    cfg_wr(8'h30, 8'h01); cfg_wr(8'hF0, 8'h3C);
    cur_req = "R8";
    hw_reset(1, 1);
    cyc(0, 1, 16'h004E, 0); cyc(0, 1, 16'h002E, 0);
    cyc(1, 0, 16'h002E, 8'h28); cyc(0, 1, 16'h002F, 0);
    cfg_rd(8'h28); cfg_rd(8'h07); cfg_rd(8'h30); cfg_rd(8'hF0); cfg_rd(8'h21);
    cur_req = "R1";
    cfg_rd(8'h07); cyc(0, 1, 16'h004F, 0);
    cur_req = "R8";
    hw_reset(0, 0);
    cfg_rd(8'h28); cfg_rd(8'h22);
    cfg_wr(8'h21, 8'h00); cfg_rd(8'h21);
    cur_req = "R10";
    repeat (4) idle();
    report();
  end
endmodule